// File: doc/BRIEF.md
# Dual-Descriptor Posted Read Sequencer

This block performs background reads on an external memory bus so that the processor or DMA engine that wants the data never stalls on the bus. Software programs a descriptor (start address, transfer size, number of transfers) and the sequencer issues one bus read at a time. Each returned value is pushed into a read FIFO, which the consumer empties through a register read. A programmable fill threshold raises a trigger output for an interrupt or DMA request.

Two descriptor sets exist and are chained. When the running set has no transfers left, the other set takes over if it holds a nonzero count. A set that has finished can be reprogrammed while its partner runs, which keeps the bus busy without gaps. Writing a zero count cancels a set. A read already handed to the bus still completes, its data still lands in the FIFO, and the set's address register advances for it. Software can therefore work out how many values were fetched.

The bus side uses a plain request/grant/data-valid handshake. In chip-select mode the top three address bits drive separate chip-select lines instead of the address.

Top module: `posted_read_seq`

## Requirements
- R1: Register write offsets are: 0 = set 0 address, 1 = set 0 size code, 2 = set 0 count, 3 = set 1 address, 4 = set 1 size code, 5 = set 1 count, 8 = control (bits [3:0] fill threshold, bit 16 chip-select mode). Reads at the same offsets return the stored values. Writing a nonzero count arms that set. An idle sequencer starts on an armed set, and set 0 is considered before set 1. All of these registers reset to zero.
- R2: bus_req rises with bus_addr, bus_size and bus_cs valid, and all four hold steady until bus_gnt is seen high at a clock edge. After a grant, no new request is raised until bus_rvalid returns the data, so at most one read is outstanding.
- R3: Size code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. Each completed read advances the issuing set's address register by that many bytes.
- R4: No request is raised while the FIFO holds DEPTH entries. Issue resumes after a pop, and no returned data is ever lost.
- R5: Returned data enters the FIFO in issue order, masked to the transfer size: the low 8 bits for code 0, the low 16 bits for code 1, all 32 bits otherwise.
- R6: Each completed read decrements the issuing set's count, which never goes below zero. When the running set's count is zero and no read is in flight, the other set runs if its count is nonzero. For example, 20 reads on set 0 followed by 10 on set 1 yield 30 FIFO entries in that order.
- R7: A finished set that is rewritten and re-armed while the other set runs is executed after the running set finishes.
- R8: Writing zero to a running set's count cancels it. A read already issued for that set still completes, its data enters the FIFO, and the set's address register advances for it.
- R9: The status register (read offset 6) has bit 0 = index of the selected set, bit 4 = busy, bit 8 = FIFO full, bit 9 = FIFO empty, bit 10 = trigger. Busy stays set from the start of a run until no set is armed and no read is in flight. After a cancel, the status pattern masked with 0x11 equals 0x10 until the canceled set's in-flight read has completed.
- R10: fifo_trig is high exactly when the threshold is nonzero and the FIFO holds at least that many entries.
- R11: With chip-select mode on, bus_cs carries the address register's top 3 bits and bus_addr carries those bits as zero. Address advances wrap inside the lower AW-3 bits and leave the top 3 bits unchanged. With the mode off, bus_cs is 0 and bus_addr is the full address.
- R12: A read at offset 7 returns the FIFO head and pops it. Reading an empty FIFO returns 0, leaves the FIFO empty and does not disturb later ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_re | input | 1 | Register read strobe (pops the FIFO at offset 7) |
| reg_raddr | input | 4 | Register read offset |
| reg_rdata | output | 32 | Register read data, combinational from reg_raddr |
| bus_req | output | 1 | Bus read request |
| bus_gnt | input | 1 | Bus grant for the pending request |
| bus_addr | output | AW | Bus read address |
| bus_size | output | 2 | Bus transfer size code |
| bus_cs | output | 3 | Chip-select enables in chip-select mode |
| bus_rvalid | input | 1 | Read data valid, one pulse per granted read |
| bus_rdata | input | 32 | Read data |
| fifo_trig | output | 1 | FIFO fill-level trigger |

## Verification
The assertions assume that the bus agent behaves well. It pulses bus_rvalid once for each granted read and only while that read is outstanding, and it grants only while bus_req is high. The bench's bus responder grants a request after a set latency and then returns exactly one data beat per grant, so it never answers without a grant and never sends a second beat. The cancel test stretches the data latency so that the zero-count write lands while a read is in flight.

// File: rtl/posted_read_seq.sv
module posted_read_seq #(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_waddr,
  input  logic [31:0]   reg_wdata,
  input  logic          reg_re,
  input  logic [3:0]    reg_raddr,
  output logic [31:0]   reg_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [2:0]    bus_cs,
  input  logic          bus_rvalid,
  input  logic [31:0]   bus_rdata,
  output logic          fifo_trig
);

  localparam int CSW = 3;
  localparam int PW  = $clog2(DEPTH);
  localparam int LW  = PW + 1;

  logic [AW-1:0] addr_q [2];
  logic [1:0]    size_q [2];
  logic [CW-1:0] cnt_q  [2];
  logic [LW-1:0] level_q;
  logic          csm_q;

  logic          engaged_q, cur_q, req_q, outst_q, iss_q, iss_csm_q;
  logic [AW-1:0] bus_addr_q;
  logic [1:0]    bus_size_q;
  logic [2:0]    bus_cs_q;

  logic [31:0]   mem [DEPTH];
  logic [LW-1:0] wp_q, rp_q, fcnt;
  logic          full, empty, push, pop;
  logic [31:0]   push_data;
  logic [AW-1:0] step, base, sum, adv_addr;
  logic [31:0]   status;

  assign fcnt  = wp_q - rp_q;
  assign full  = (fcnt == LW'(DEPTH));
  assign empty = (fcnt == '0);
  assign push  = bus_rvalid && outst_q;
  assign pop   = reg_re && (reg_raddr == 4'd7) && !empty;

  assign fifo_trig = (level_q != '0) && (fcnt >= level_q);
  assign bus_req   = req_q;
  assign bus_addr  = bus_addr_q;
  assign bus_size  = bus_size_q;
  assign bus_cs    = bus_cs_q;

  always_comb begin
    case (bus_size_q)
      2'd0:    step = AW'(1);
      2'd1:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  assign base     = addr_q[iss_q];
  assign sum      = base + step;
  assign adv_addr = iss_csm_q ? {base[AW-1:AW-CSW], sum[AW-CSW-1:0]} : sum;

  always_comb begin
    case (bus_size_q)
      2'd0:    push_data = {24'd0, bus_rdata[7:0]};
      2'd1:    push_data = {16'd0, bus_rdata[15:0]};
      default: push_data = bus_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        addr_q[i] <= '0;
        size_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
      level_q <= '0;
      csm_q   <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (push && (iss_q == 1'(i))) begin
          addr_q[i] <= adv_addr;
          if (cnt_q[i] != '0) cnt_q[i] <= cnt_q[i] - 1'b1;
        end
        if (reg_we && reg_waddr == 4'(3*i))     addr_q[i] <= reg_wdata[AW-1:0];
        if (reg_we && reg_waddr == 4'(3*i + 1)) size_q[i] <= reg_wdata[1:0];
        if (reg_we && reg_waddr == 4'(3*i + 2)) cnt_q[i]  <= reg_wdata[CW-1:0];
      end
      if (reg_we && reg_waddr == 4'd8) begin
        level_q <= reg_wdata[LW-1:0];
        csm_q   <= reg_wdata[16];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      engaged_q  <= 1'b0;
      cur_q      <= 1'b0;
      req_q      <= 1'b0;
      outst_q    <= 1'b0;
      iss_q      <= 1'b0;
      iss_csm_q  <= 1'b0;
      bus_addr_q <= '0;
      bus_size_q <= '0;
      bus_cs_q   <= '0;
    end else begin
      if (!engaged_q) begin
        if (cnt_q[0] != '0) begin
          engaged_q <= 1'b1;
          cur_q     <= 1'b0;
        end else if (cnt_q[1] != '0) begin
          engaged_q <= 1'b1;
          cur_q     <= 1'b1;
        end
      end else if (!req_q && !outst_q) begin
        if (cnt_q[cur_q] != '0) begin
          if (!full) begin
            req_q      <= 1'b1;
            iss_q      <= cur_q;
            iss_csm_q  <= csm_q;
            bus_size_q <= size_q[cur_q];
            bus_addr_q <= csm_q ? {CSW'(0), addr_q[cur_q][AW-CSW-1:0]} : addr_q[cur_q];
            bus_cs_q   <= csm_q ? addr_q[cur_q][AW-1:AW-CSW] : '0;
          end
        end else if (cnt_q[!cur_q] != '0) begin
          cur_q <= !cur_q;
        end else begin
          engaged_q <= 1'b0;
        end
      end
      if (req_q && bus_gnt) begin
        req_q   <= 1'b0;
        outst_q <= 1'b1;
      end
      if (push) outst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
    end
  end

  always_comb begin
    status     = '0;
    status[0]  = cur_q;
    status[4]  = engaged_q;
    status[8]  = full;
    status[9]  = empty;
    status[10] = fifo_trig;
  end

  always_comb begin
    case (reg_raddr)
      4'd0:    reg_rdata = 32'(addr_q[0]);
      4'd1:    reg_rdata = {30'd0, size_q[0]};
      4'd2:    reg_rdata = 32'(cnt_q[0]);
      4'd3:    reg_rdata = 32'(addr_q[1]);
      4'd4:    reg_rdata = {30'd0, size_q[1]};
      4'd5:    reg_rdata = 32'(cnt_q[1]);
      4'd6:    reg_rdata = status;
      4'd7:    reg_rdata = empty ? 32'd0 : mem[rp_q[PW-1:0]];
      4'd8:    reg_rdata = 32'(level_q) | (32'(csm_q) << 16);
      default: reg_rdata = 32'd0;
    endcase
  end

endmodule

module posted_read_seq_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [2:0]    bus_cs,
  input logic          bus_rvalid,
  input logic          outst,
  input logic          busy,
  input logic [LW-1:0] fcnt
);

  a_r2_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_size) && $stable(bus_cs));

  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !bus_req);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= LW'(DEPTH));

  a_r4_no_req_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(fcnt) < LW'(DEPTH));

  a_r9_busy_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || outst) |-> busy);

  a_r8_data_only_when_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> outst);

endmodule

bind posted_read_seq posted_read_seq_chk #(.AW(AW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_cs(bus_cs),
  .bus_rvalid(bus_rvalid), .outst(outst_q), .busy(engaged_q), .fcnt(fcnt)
);

// File: tb/sim_posted_read_seq.sv
module sim_posted_read_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_re;
  logic [3:0]  reg_waddr, reg_raddr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        bus_req, bus_gnt, bus_rvalid, fifo_trig;
  logic [31:0] bus_addr, bus_rdata;
  logic [1:0]  bus_size;
  logic [2:0]  bus_cs;

  always #2 clk = ~clk;

  posted_read_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_re(reg_re), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_cs(bus_cs),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .fifo_trig(fifo_trig)
  );

  int n_chk = 0, n_bad = 0;
  int gnt_lat = 1, rd_lat = 1;
  int rsp_st = 0;
  int log_n = 0;
  logic [31:0] log_addr [64];
  logic [2:0]  log_cs   [64];
  logic [31:0] expv     [64];

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'h5EED_C0DE;
  endfunction

  task automatic chk_eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // bus responder: grant after gnt_lat cycles, data rd_lat cycles after grant
  initial begin
    int gc, dc;
    logic [31:0] cap;
    bus_gnt = 1'b0; bus_rvalid = 1'b0; bus_rdata = '0;
    gc = 0; dc = 0; cap = '0;
    forever begin
      @(negedge clk);
      bus_gnt = 1'b0;
      bus_rvalid = 1'b0;
      if (!rst_n) begin
        rsp_st = 0; gc = 0;
      end else if (rsp_st == 0) begin
        if (bus_req) begin
          if (gc >= gnt_lat) begin
            bus_gnt = 1'b1;
            cap = bus_addr;
            if (log_n < 64) begin
              log_addr[log_n] = bus_addr;
              log_cs[log_n] = bus_cs;
            end
            log_n++;
            rsp_st = 1; dc = 0; gc = 0;
          end else gc++;
        end
      end else begin
        if (dc >= rd_lat) begin
          bus_rvalid = 1'b1;
          bus_rdata = memf(cap);
          rsp_st = 0;
        end else dc++;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_raddr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (2) @(negedge clk);
    for (int g = 0; g < 3000; g++) begin
      rd(4'd6, s);
      if (!s[4] && !bus_req) break;
    end
  endtask

  task automatic drain(input int n, input string rq);
    logic [31:0] d;
    int k = 0;
    for (int g = 0; g < 5000 && k < n; g++) begin
      rd(4'd6, d);
      if (!d[9]) begin
        rd(4'd7, d);
        chk_eq(rq, d, expv[k]);
        k++;
      end
    end
    if (k < n) chk_eq({rq, " drain timeout"}, k, n);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd6, d);   chk_eq("R9 status after reset", d, 32'h200);
    chk_eq("R2 no request after reset", bus_req, 1'b0);
    chk_eq("R10 trigger low after reset", fifo_trig, 1'b0);
    rd(4'd2, d);   chk_eq("R1 count0 reset", d, 0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    log_n = 0;
    wr(4'd0, 32'h100); wr(4'd1, 2); wr(4'd2, 5);
    wait_idle();
    rd(4'd0, d); chk_eq("R3 address after five word reads", d, 32'h114);
    rd(4'd2, d); chk_eq("R6 count reaches zero", d, 0);
    chk_eq("R1 five reads issued", log_n, 5);
    chk_eq("R2 fifth address", log_addr[4], 32'h110);
    chk_eq("R11 cs zero with mode off", log_cs[0], 3'd0);
    for (int k = 0; k < 5; k++) expv[k] = memf(32'h100 + 4 * k);
    drain(5, "R5 single set data");
  endtask

  task automatic t_chain();
    logic [31:0] d;
    log_n = 0;
    wr(4'd0, 32'h1000); wr(4'd1, 2); wr(4'd2, 20);
    wr(4'd3, 32'h2000); wr(4'd4, 1); wr(4'd5, 10);
    repeat (200) @(negedge clk);
    rd(4'd6, d);
    chk_eq("R4 fifo full flag", d[8], 1'b1);
    chk_eq("R4 request held off while full", bus_req, 1'b0);
    chk_eq("R4 exactly depth reads issued", log_n, 8);
    for (int k = 0; k < 20; k++) expv[k] = memf(32'h1000 + 4 * k);
    for (int k = 0; k < 10; k++) expv[20 + k] = memf(32'h2000 + 2 * k) & 32'hFFFF;
    drain(30, "R6 chained 20 plus 10");
    wait_idle();
    rd(4'd5, d); chk_eq("R6 count1 drained", d, 0);
    rd(4'd3, d); chk_eq("R3 half-word step", d, 32'h2014);
  endtask

  task automatic t_rearm();
    logic [31:0] d;
    wr(4'd0, 32'h300); wr(4'd1, 0); wr(4'd2, 3);
    wr(4'd3, 32'h400); wr(4'd4, 2); wr(4'd5, 6);
    for (int g = 0; g < 500; g++) begin
      rd(4'd6, d);
      if (d[0]) break;
    end
    chk_eq("R7 set 1 selected before re-arm", d[0], 1'b1);
    wr(4'd0, 32'h500); wr(4'd2, 2);
    for (int k = 0; k < 3; k++) expv[k] = memf(32'h300 + k) & 32'hFF;
    for (int k = 0; k < 6; k++) expv[3 + k] = memf(32'h400 + 4 * k);
    for (int k = 0; k < 2; k++) expv[9 + k] = memf(32'h500 + k) & 32'hFF;
    drain(11, "R7 re-armed set runs after partner");
    wait_idle();
    rd(4'd0, d); chk_eq("R3 byte step", d, 32'h502);
  endtask

  task automatic t_cancel();
    logic [31:0] d;
    rd_lat = 20; log_n = 0;
    wr(4'd0, 32'h600); wr(4'd1, 2); wr(4'd2, 10);
    for (int g = 0; g < 200 && rsp_st != 1; g++) @(negedge clk);
    wr(4'd2, 0);
    rd(4'd6, d); chk_eq("R9 cancel pending pattern", d & 32'h11, 32'h10);
    for (int g = 0; g < 200; g++) begin
      rd(4'd6, d);
      if ((d & 32'h11) != 32'h10) break;
    end
    chk_eq("R9 idle after cancel", d[4], 1'b0);
    rd(4'd0, d); chk_eq("R8 address counts in-flight read", d, 32'h604);
    chk_eq("R8 no further reads", log_n, 1);
    expv[0] = memf(32'h600);
    drain(1, "R8 in-flight data kept");
    rd(4'd6, d); chk_eq("R12 empty after drain", d[9], 1'b1);
    rd_lat = 1;
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    wr(4'd8, 3);
    wr(4'd0, 32'h700); wr(4'd1, 2); wr(4'd2, 3);
    wait_idle();
    chk_eq("R10 trigger at threshold", fifo_trig, 1'b1);
    rd(4'd7, d); chk_eq("R12 pop head", d, memf(32'h700));
    chk_eq("R10 trigger below threshold", fifo_trig, 1'b0);
    wr(4'd8, 0);
    chk_eq("R10 zero threshold disables", fifo_trig, 1'b0);
    expv[0] = memf(32'h704); expv[1] = memf(32'h708);
    drain(2, "R10 remaining data");
  endtask

  task automatic t_csmode();
    logic [31:0] d;
    log_n = 0;
    wr(4'd8, 32'h1_0000);
    wr(4'd0, 32'h3FFF_FFFC); wr(4'd1, 2); wr(4'd2, 2);
    wait_idle();
    chk_eq("R11 first cs", log_cs[0], 3'd1);
    chk_eq("R11 first address", log_addr[0], 32'h1FFF_FFFC);
    chk_eq("R11 second cs", log_cs[1], 3'd1);
    chk_eq("R11 wrap inside low bits", log_addr[1], 32'h0);
    rd(4'd0, d); chk_eq("R11 cs bits kept in register", d, 32'h2000_0004);
    expv[0] = memf(32'h1FFF_FFFC); expv[1] = memf(32'h0);
    drain(2, "R11 data");
    wr(4'd8, 0);
  endtask

  task automatic t_empty();
    logic [31:0] d;
    rd(4'd7, d); chk_eq("R12 empty read returns zero", d, 0);
    rd(4'd7, d); chk_eq("R12 second empty read", d, 0);
    rd(4'd6, d); chk_eq("R12 still empty, not full", d[9:8], 2'b10);
    wr(4'd3, 32'h800); wr(4'd4, 2); wr(4'd5, 1);
    wait_idle();
    expv[0] = memf(32'h800);
    drain(1, "R12 order intact after empty reads");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0;
    reg_waddr = '0; reg_raddr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_chain();
    t_rearm();
    t_cancel();
    t_trigger();
    t_csmode();
    t_empty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule